// File: doc/BRIEF.md
# Two-Error-Correcting (15,7) Binary Block Decoder

This block takes one received 15-bit code word of a binary (15,7) cyclic code with designed distance 5, delivered as fifteen signed soft samples in parallel. Each sample is turned into a bit by a zero-threshold slicer. The decoder then corrects up to two bit errors and hands back the seven message bits together with two status flags. It is meant to sit after a demodulator in a hard-decision receive path. A word goes in through a valid/ready handshake, and the result comes out through a second valid/ready handshake.

Internally the decoder forms two syndrome values over GF(16), with field polynomial x^4+x+1, by a bit-serial Horner pass over the word. It then picks one of four cases: clean word, one error, two errors, or not correctable. For the two-error case it finds the roots of the quadratic error locator by stepping through all fifteen positions, one per clock. Every word takes the same number of cycles. Only one word is in flight, so a new word is taken only after the previous result has been handed off.

Top module: `bch_dec15`

## Requirements
- R1: Sample i (bits [i*SW +: SW] of `in_samples`, two's complement) becomes code bit i. It becomes 1 when the sample is strictly greater than zero, and 0 when it is zero or negative.
- R2: When the code word polynomial r(x) = sum of r_i x^i has r(α) = 0 and r(α^3) = 0, `out_msg` equals received bits 14..8 (bit 14 at `out_msg[6]`) and both flags are 0.
- R3: A word with exactly one bit error, at any of the 15 positions, parity positions included, yields the original message with `out_corrected` = 1 and `out_uncorrectable` = 0.
- R4: A word with exactly two bit errors, at any pair of positions, yields the original message with `out_corrected` = 1 and `out_uncorrectable` = 0.
- R5: When no valid code word lies within Hamming distance 2 of the received word, `out_msg` equals received bits 14..8 unchanged, `out_uncorrectable` = 1 and `out_corrected` = 0. The two flags are never 1 together.
- R6: `in_ready` is 1 only while the decoder is idle and is 0 whenever `out_valid` is 1. While `out_valid` = 1 and `out_ready` = 0, the outputs hold steady. `out_valid` falls in the cycle after the output handshake.
- R7: `out_valid` rises exactly 31 clock edges after the edge on which a word is accepted, whatever the error pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Received word present |
| in_ready | output | 1 | Decoder idle and able to take a word |
| in_samples | input | 15*SW | Fifteen signed soft samples, sample i in bits [i*SW +: SW] |
| out_valid | output | 1 | Decoded result present |
| out_ready | input | 1 | Consumer takes the result |
| out_msg | output | 7 | Decoded message bits (code positions 14..8) |
| out_corrected | output | 1 | One or two bits were inverted |
| out_uncorrectable | output | 1 | More than two errors detected, word passed through |

## Verification
The bench walks a single error through every one of the 15 positions, so a wrong log table or a wrong bit order would corrupt one or more of them. It also applies double errors at the end positions and at the message/parity seam, where a wrong root-search step would fix the wrong bits. Samples of exactly zero and of the most negative value probe the slicer; a threshold of greater-or-equal would inject extra errors. Words with three and four errors are checked against a brute-force nearest-codeword search, which catches a decoder that flips bits after finding the wrong number of roots. Random output stalls catch results that change under backpressure or a second word accepted early.

// File: rtl/bch_dec15.sv
module bch_dec15 #(
  parameter int SW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [15*SW-1:0] in_samples,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [6:0]      out_msg,
  output logic            out_corrected,
  output logic            out_uncorrectable
);
  localparam int N = 15;
  localparam int K = 7;
  localparam int LATENCY = 31;

  typedef enum logic [2:0] {IDLE, SYN, SOLVE, CHIEN, DONE} st_t;

  function automatic logic [3:0] gmul(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] p, x;
    p = '0;
    x = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) p = p ^ x;
      x = {x[2:0], 1'b0} ^ (x[3] ? 4'h3 : 4'h0);
    end
    return p;
  endfunction

  function automatic logic [3:0] apow(input int e);
    logic [3:0] v;
    v = 4'h1;
    for (int i = 0; i < e; i++) v = gmul(v, 4'h2);
    return v;
  endfunction

  function automatic logic [3:0] ginv(input logic [3:0] a);
    logic [3:0] r;
    r = '0;
    for (int b = 1; b < 16; b++)
      if (gmul(a, 4'(b)) == 4'h1) r = 4'(b);
    return r;
  endfunction

  function automatic logic [3:0] glog(input logic [3:0] a);
    logic [3:0] r;
    r = '0;
    for (int i = 0; i < N; i++)
      if (apow(i) == a) r = 4'(i);
    return r;
  endfunction

  st_t         st;
  logic [N-1:0] word, roots;
  logic [3:0]  cnt, s1, s3, t1, t2;
  logic        dbl, corr, unc;

  logic [N-1:0] hard;
  for (genvar gi = 0; gi < N; gi++) begin : g_slice
    assign hard[gi] = $signed(in_samples[gi*SW +: SW]) > 0;
  end

  logic [3:0]  cval;
  logic        hit;
  logic [N-1:0] roots_n;
  logic [3:0]  s1_cube;
  assign cval    = 4'h1 ^ t1 ^ t2;
  assign hit     = dbl && (cval == 4'h0);
  assign roots_n = roots | (hit ? (N'(1) << cnt) : '0);
  assign s1_cube = gmul(gmul(s1, s1), s1);

  assign in_ready          = (st == IDLE);
  assign out_valid         = (st == DONE);
  assign out_msg           = word[N-1 -: K];
  assign out_corrected     = corr;
  assign out_uncorrectable = unc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; word <= '0; roots <= '0; cnt <= '0;
      s1 <= '0; s3 <= '0; t1 <= '0; t2 <= '0;
      dbl <= 1'b0; corr <= 1'b0; unc <= 1'b0;
    end else begin
      case (st)
        IDLE: if (in_valid) begin
          word <= hard; cnt <= 4'(N-1);
          s1 <= '0; s3 <= '0; roots <= '0;
          dbl <= 1'b0; corr <= 1'b0; unc <= 1'b0;
          st <= SYN;
        end
        SYN: begin
          s1 <= gmul(s1, 4'h2) ^ {3'b0, word[cnt]};
          s3 <= gmul(s3, 4'h8) ^ {3'b0, word[cnt]};
          if (cnt == 0) st <= SOLVE;
          else cnt <= cnt - 1'b1;
        end
        SOLVE: begin
          cnt <= '0;
          st  <= CHIEN;
          if (s1 == 4'h0 && s3 == 4'h0) begin
            corr <= 1'b0;
          end else if (s1 != 4'h0 && s3 == s1_cube) begin
            word <= word ^ (N'(1) << glog(s1));
            corr <= 1'b1;
          end else if (s1 == 4'h0) begin
            unc <= 1'b1;
          end else begin
            dbl <= 1'b1;
            t1  <= s1;
            t2  <= gmul(s3, ginv(s1)) ^ gmul(s1, s1);
          end
        end
        CHIEN: begin
          roots <= roots_n;
          t1 <= gmul(t1, 4'h9);
          t2 <= gmul(t2, 4'hD);
          if (cnt == 4'(N-1)) begin
            st <= DONE;
            if (dbl) begin
              if ($countones(roots_n) == 2) begin
                word <= word ^ roots_n;
                corr <= 1'b1;
              end else begin
                unc <= 1'b1;
              end
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        DONE: if (out_ready) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  logic [5:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else if (in_valid && in_ready) lat_q <= '0;
    else if (!out_valid && !in_ready && lat_q != 6'h3F) lat_q <= lat_q + 1'b1;
  end

  assert_ready_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  assert_hold_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_msg) &&
      $stable(out_corrected) && $stable(out_uncorrectable)));
  assert_drop_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);
  assert_flags_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_corrected && out_uncorrectable));
  assert_fixed_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_q == 6'(LATENCY)));
endmodule

// File: tb/bch_dec15_tb.sv
module bch_dec15_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [15*SW-1:0] in_samples = '0;
  logic in_ready, out_valid, out_corrected, out_uncorrectable;
  logic [6:0] out_msg;

  bch_dec15 #(.SW(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_samples(in_samples), .out_valid(out_valid), .out_ready(out_ready),
    .out_msg(out_msg), .out_corrected(out_corrected),
    .out_uncorrectable(out_uncorrectable));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0, n_unc_seen = 0;
  bit finished = 0;
  logic [6:0] q_msg[$];
  logic       q_cor[$], q_unc[$];
  int         q_acc[$];
  string      q_tag[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [14:0] encode(input logic [6:0] m);
    logic [14:0] rem;
    rem = {m, 8'h00};
    for (int i = 14; i >= 8; i--)
      if (rem[i]) rem = rem ^ (15'h1D1 << (i - 8));
    return {m, rem[7:0]};
  endfunction

  task automatic send(input logic [14:0] cw, input logic [14:0] err,
                      input bit edge_samples, input string tag_in);
    logic [14:0] r;
    logic [6:0] em;
    logic ec, eu;
    int best_d, best_m;
    string tag;
    logic signed [SW-1:0] s;
    r = cw ^ err;
    best_d = 99; best_m = 0;
    for (int m = 0; m < 128; m++) begin
      int d;
      d = $countones(encode(7'(m)) ^ r);
      if (d < best_d) begin best_d = d; best_m = m; end
    end
    if (best_d <= 2) begin
      em = 7'(best_m); ec = (best_d > 0); eu = 1'b0;
      tag = tag_in;
    end else begin
      em = r[14:8]; ec = 1'b0; eu = 1'b1; tag = "R5";
    end
    @(negedge clk);
    for (int i = 0; i < 15; i++) begin
      if (r[i]) s = edge_samples ? SW'(1) : SW'(1 + ($urandom % 127));
      else if (edge_samples) s = (i % 2) ? SW'(0) : {1'b1, {(SW-1){1'b0}}};
      else s = -SW'($urandom % 128);
      in_samples[i*SW +: SW] = s;
    end
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    q_msg.push_back(em); q_cor.push_back(ec); q_unc.push_back(eu);
    q_acc.push_back(cyc + 1); q_tag.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (out_valid) begin
        if (q_msg.size() == 0) begin
          chk(1'b0, "R6", "unexpected output", 1, 0);
        end else begin
          logic [6:0] em; logic ec, eu; int acc; string tg; int stall;
          em = q_msg.pop_front(); ec = q_cor.pop_front(); eu = q_unc.pop_front();
          acc = q_acc.pop_front(); tg = q_tag.pop_front();
          if (eu) n_unc_seen++;
          chk(cyc - acc == 31, "R7", "latency", cyc - acc, 31);
          chk(out_msg == em, tg, "msg", out_msg, em);
          chk({out_corrected, out_uncorrectable} == {ec, eu}, tg, "flags",
              {out_corrected, out_uncorrectable}, {ec, eu});
          chk(!in_ready, "R6", "in_ready during output", in_ready, 0);
          stall = n_chk % 4;
          repeat (stall) begin
            @(negedge clk);
            chk(out_valid && out_msg == em && out_corrected == ec &&
                out_uncorrectable == eu, "R6", "hold under stall",
                {out_valid, out_msg}, {1'b1, em});
          end
          out_ready = 1'b1;
          @(negedge clk);
          out_ready = 1'b0;
          chk(!out_valid && in_ready, "R6", "release after handshake",
              {out_valid, in_ready}, 2'b01);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : driver
    logic [14:0] cw;
    repeat (3) @(negedge clk);
    chk(!out_valid && in_ready, "R6", "reset state", {out_valid, in_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: clean words
    send(encode(7'h00), 15'h0, 1'b0, "R2");
    send(encode(7'h7F), 15'h0, 1'b0, "R2");
    send(encode(7'h5A), 15'h0, 1'b0, "R2");
    // R1: boundary samples (+1, 0, most negative)
    send(encode(7'h33), 15'h0, 1'b1, "R1");
    send(encode(7'h4C), 15'h0, 1'b1, "R1");
    send(encode(7'h21), 15'h0100, 1'b1, "R1");
    // R3: single error at every position
    for (int p = 0; p < 15; p++) begin
      cw = encode(7'($urandom % 128));
      send(cw, 15'(1) << p, 1'b0, "R3");
    end
    // R4: double errors at edges and seams, then random pairs
    send(encode(7'h12), 15'h4001, 1'b0, "R4");
    send(encode(7'h6D), 15'h0180, 1'b0, "R4");
    send(encode(7'h3E), 15'h0003, 1'b0, "R4");
    send(encode(7'h41), 15'h6000, 1'b0, "R4");
    for (int k = 0; k < 12; k++) begin
      int a, b;
      a = $urandom % 15;
      b = (a + 1 + ($urandom % 14)) % 15;
      send(encode(7'($urandom % 128)), (15'(1) << a) | (15'(1) << b), 1'b0, "R4");
    end
    // R5: three and four errors
    for (int k = 0; k < 16; k++) begin
      logic [14:0] e;
      e = '0;
      while ($countones(e) < 3 + (k % 2)) e = e | (15'(1) << ($urandom % 15));
      send(encode(7'($urandom % 128)), e, 1'b0, "R5");
    end
    while (q_msg.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(n_unc_seen > 0, "R5", "uncorrectable case reached", n_unc_seen, 1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule